// File: doc/BRIEF.md
# PMIC Power and Warm-Reset Handshake Sequencer

This block runs the button-style handshakes that a power management IC expects on two active-low open-drain lines: a key-power line and a reset-input line. A power-on command holds the key-power line low until power-good rises. A power-off command holds both lines low until power-good falls. A warm-reset command pulses the reset-input line low for a fixed number of milliseconds and then watches the processor reset line for an acknowledge. Every wait is bounded and counted in millisecond ticks.

Each command ends with a one-cycle done pulse and a result. The error flag marks a refused or timed-out power command. The cold-reset-needed flag marks a warm reset that the processor never acknowledged, so the system controller above can fall back to a full power cycle. Both flags hold until the next command is accepted.

Top module: `pmic_handshake_seq`

## Requirements
- R1: After reset both drive lines are released (high), and busy, done, err and cold_needed are low.
- R2: A power-on command with pgood already high, or a power-off command with pgood already low, gives done in the next cycle with err low, busy never high and no line driven.
- R3: When a command needs to drive a line and resin_rb reads low, the block drives nothing, stays idle and gives done in the next cycle with err high.
- R4: Power-on holds kpd_drive_n low and resin_drive_n high. pgood is sampled on each tick, and a high sample ends the wait on that tick with done and err low.
- R5: Power-off holds both kpd_drive_n and resin_drive_n low until a tick samples pgood low, then releases both with done and err low.
- R6: If pgood has not reached the target by the WAIT_MS-th tick of a power wait, both lines are released and done comes with err high.
- R7: Warm reset holds resin_drive_n low for exactly PULSE_MS ticks, with kpd_drive_n high throughout. It then releases the line and samples ap_rst_n on up to WAIT_MS ticks. A low sample, or ap_rst_n already low on the first such tick, gives done with both flags low.
- R8: If ap_rst_n stays high for all WAIT_MS ticks of the acknowledge wait, done comes with cold_needed high and err low.
- R9: Commands that arrive while busy have no effect on the lines or on the result. If several strobes arrive together while idle, power-on wins over power-off, and power-off wins over warm reset.
- R10: done is high for one cycle only. err and cold_needed keep their value until the next accepted command clears them.
- R11: While busy, the drive lines change only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe per millisecond |
| cmd_on | input | 1 | Power-on command strobe |
| cmd_off | input | 1 | Power-off command strobe |
| cmd_warm | input | 1 | Warm-reset command strobe |
| pgood | input | 1 | Power-good from the PMIC |
| resin_rb | input | 1 | Readback of the reset-input line |
| ap_rst_n | input | 1 | Processor reset line, low when asserted |
| kpd_drive_n | output | 1 | Key-power line drive, low = pull down |
| resin_drive_n | output | 1 | Reset-input line drive, low = pull down |
| busy | output | 1 | A handshake is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command was refused or timed out |
| cold_needed | output | 1 | Last warm reset was not acknowledged |

## Verification
The hardest case to reach from the ports is a response that lands exactly on the last tick of a bounded wait, or a warm-reset acknowledge that arrives while the pulse is still being driven. Only then does the order of the tick comparison decide between success and timeout. The stimulus builds its own tick train and chooses the tick index at which power-good or the processor reset responds. Random indices just inside and just past the window are mixed with directed runs at those edges. Some runs also inject command strobes in the middle of a wait, to show that they are ignored.

// File: rtl/pmic_handshake_seq.sv
module pmic_handshake_seq #(
  parameter int WAIT_MS  = 350,
  parameter int PULSE_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic cmd_on,
  input  logic cmd_off,
  input  logic cmd_warm,
  input  logic pgood,
  input  logic resin_rb,
  input  logic ap_rst_n,
  output logic kpd_drive_n,
  output logic resin_drive_n,
  output logic busy,
  output logic done,
  output logic err,
  output logic cold_needed
);
  localparam int LIM = (WAIT_MS > PULSE_MS) ? WAIT_MS : PULSE_MS;
  localparam int CW  = $clog2(LIM + 1);
  localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_MS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_MS - 1);

  typedef enum logic [2:0] {S_IDLE, S_PON, S_POFF, S_PULSE, S_ACK} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  wire any_cmd  = cmd_on | cmd_off | cmd_warm;
  wire want_on  = cmd_on;
  wire want_off = !cmd_on && cmd_off;
  wire pg_hit   = (st == S_PON) ? pgood : !pgood;
  wire wait_end = (cnt == WAIT_LAST);

  assign busy          = (st != S_IDLE);
  assign kpd_drive_n   = !((st == S_PON) || (st == S_POFF));
  assign resin_drive_n = !((st == S_POFF) || (st == S_PULSE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      done <= 1'b0;
      err <= 1'b0;
      cold_needed <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (any_cmd) begin
          err <= 1'b0;
          cold_needed <= 1'b0;
          cnt <= '0;
          if ((want_on || want_off) && (pgood == want_on)) done <= 1'b1;
          else if (!resin_rb) begin
            err <= 1'b1;
            done <= 1'b1;
          end else st <= want_on ? S_PON : (want_off ? S_POFF : S_PULSE);
        end
        S_PON, S_POFF: if (tick_ms) begin
          if (pg_hit) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else if (wait_end) begin
            err <= 1'b1;
            done <= 1'b1;
            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_PULSE: if (tick_ms) begin
          if (cnt == PULSE_LAST) begin
            cnt <= '0;
            st <= S_ACK;
          end else cnt <= cnt + 1'b1;
        end
        S_ACK: if (tick_ms) begin
          if (!ap_rst_n) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else if (wait_end) begin
            cold_needed <= 1'b1;
            done <= 1'b1;
            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_tick_paced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_ms) |=> ($stable(kpd_drive_n) && $stable(resin_drive_n)));
  p_abort_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && any_cmd && !resin_rb) |=> (!busy && done));
  p_cold_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_needed) |-> (done && !err));
  p_err_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

// File: tb/sim_pmic_handshake_seq.sv
module sim_pmic_handshake_seq;
  localparam int CLK_P = 10;
  localparam int W = 6;
  localparam int P = 3;
  localparam int TPER = 3;

  logic clk = 0, rst_n = 0, tick_ms = 0;
  logic cmd_on = 0, cmd_off = 0, cmd_warm = 0;
  logic pgood = 0, resin_rb = 1, ap_rst_n = 1;
  logic kpd_drive_n, resin_drive_n, busy, done, err, cold_needed;
  int checks = 0, fails = 0;

  pmic_handshake_seq #(.WAIT_MS(W), .PULSE_MS(P)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .cmd_on(cmd_on), .cmd_off(cmd_off), .cmd_warm(cmd_warm),
    .pgood(pgood), .resin_rb(resin_rb), .ap_rst_n(ap_rst_n),
    .kpd_drive_n(kpd_drive_n), .resin_drive_n(resin_drive_n),
    .busy(busy), .done(done), .err(err), .cold_needed(cold_needed));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 power-on, 1 power-off, 2 warm reset
  function automatic string exp_req(input int kind, input bit pg0, input bit rb, input int k);
    if (kind != 2 && pg0 == (kind == 0)) return "R2";
    if (!rb) return "R3";
    if (kind == 0) return (k <= W) ? "R4" : "R6";
    if (kind == 1) return (k <= W) ? "R5" : "R6";
    return (k <= P + W) ? "R7" : "R8";
  endfunction

  function automatic int exp_tick(input int kind, input bit pg0, input bit rb, input int k);
    if (kind != 2 && pg0 == (kind == 0)) return 0;
    if (!rb) return 0;
    if (kind != 2) return (k <= W) ? k : W;
    if (k > P + W) return P + W;
    return (k > P) ? k : P + 1;
  endfunction

  function automatic bit exp_err(input int kind, input bit pg0, input bit rb, input int k);
    if (kind != 2 && pg0 == (kind == 0)) return 0;
    if (!rb) return 1;
    if (kind != 2) return k > W;
    return 0;
  endfunction

  function automatic bit exp_cold(input int kind, input bit pg0, input bit rb, input int k);
    if (kind != 2 && pg0 == (kind == 0)) return 0;
    if (!rb) return 0;
    return (kind == 2) && (k > P + W);
  endfunction

  task automatic run_cmd(input int kind, input bit pg0, input bit rb, input int k,
                         input bit all_strobes, input int inj);
    string rq = exp_req(kind, pg0, rb, k);
    int t = 0, gt = -1, pticks = 0;
    bit got = 0, bad = 0;
    bit ekpd, eres;
    @(negedge clk);
    pgood = pg0; resin_rb = rb; ap_rst_n = 1;
    cmd_on = (kind == 0) || all_strobes;
    cmd_off = (kind == 1) || all_strobes;
    cmd_warm = (kind == 2) || all_strobes;
    @(negedge clk);
    cmd_on = 0; cmd_off = 0; cmd_warm = 0;
    for (int c = 0; c < 400 && !got; c++) begin
      if (done) begin
        got = 1;
        gt = t;
      end else begin
        ekpd = (kind == 2);
        eres = (kind == 1) ? 1'b0 : (kind == 2) ? (t >= P) : 1'b1;
        if (!busy || kpd_drive_n != ekpd || resin_drive_n != eres) bad = 1;
        if (c % TPER == TPER - 1) begin
          t++;
          if (t == k) begin
            if (kind == 0) pgood = 1;
            else if (kind == 1) pgood = 0;
            else ap_rst_n = 0;
          end
          if (!resin_drive_n) pticks++;
          tick_ms = 1;
        end
        if (inj != 0 && t == inj && c % TPER == 0) begin
          cmd_on = 1; cmd_off = 1; cmd_warm = 1;
        end
        @(negedge clk);
        tick_ms = 0;
        cmd_on = 0; cmd_off = 0; cmd_warm = 0;
      end
    end
    chk(got, rq, got, 1);
    chk(err == exp_err(kind, pg0, rb, k), rq, err, exp_err(kind, pg0, rb, k));
    chk(cold_needed == exp_cold(kind, pg0, rb, k), rq, cold_needed, exp_cold(kind, pg0, rb, k));
    chk(gt == exp_tick(kind, pg0, rb, k), rq, gt, exp_tick(kind, pg0, rb, k));
    chk(!bad, (inj != 0) ? "R9" : rq, bad, 0);
    if (kind == 2 && exp_tick(kind, pg0, rb, k) != 0)
      chk(pticks == P, "R7", pticks, P);
    chk(kpd_drive_n && resin_drive_n && !busy, rq, {kpd_drive_n, resin_drive_n, !busy}, 7);
    @(negedge clk);
    chk(!done, "R10", done, 0);
    ap_rst_n = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(kpd_drive_n && resin_drive_n, "R1", {kpd_drive_n, resin_drive_n}, 3);
    chk(!busy && !done && !err && !cold_needed, "R1", {busy, done, err, cold_needed}, 0);
    rst_n = 1;
    @(negedge clk);

    run_cmd(0, 1, 1, 1, 0, 0);      // R2 already on
    run_cmd(1, 0, 1, 1, 0, 0);      // R2 already off
    run_cmd(0, 0, 0, 1, 0, 0);      // R3 abort
    run_cmd(2, 1, 0, 1, 0, 0);      // R3 abort warm
    run_cmd(0, 0, 1, W, 0, 0);      // R4 last tick success
    run_cmd(1, 1, 1, W + 1, 0, 0);  // R6 timeout
    repeat (5) @(negedge clk);
    chk(err == 1, "R10", err, 1);
    run_cmd(0, 1, 1, 1, 0, 0);      // clears err (R10)
    run_cmd(2, 1, 1, 1, 0, 0);      // R7 ack during pulse
    run_cmd(2, 1, 1, P + W, 0, 0);  // R7 ack on last tick
    run_cmd(2, 1, 1, P + W + 1, 0, 0); // R8 cold needed
    repeat (4) @(negedge clk);
    chk(cold_needed == 1, "R10", cold_needed, 1);
    run_cmd(0, 0, 1, 3, 1, 0);      // R9 priority: on wins
    run_cmd(1, 1, 1, W + 2, 0, 2);  // R9 strobes while busy
    run_cmd(2, 1, 1, W + P + 3, 0, 4); // R9 warm with injection

    for (int i = 0; i < 60; i++) begin
      int kind = $urandom_range(0, 2);
      bit pg0 = 1'($urandom_range(0, 1));
      bit rb = ($urandom_range(0, 7) != 0);
      int k = $urandom_range(1, P + W + 2);
      int inj = ($urandom_range(0, 3) == 0) ? 1 : 0;
      run_cmd(kind, pg0, rb, k, 0, inj);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule